// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital timing controller of a dual-slope integrating converter. It steps the analog front end through a fixed cycle: auto-zero, then signal integrate, then reference de-integrate, then zero-integrator. During de-integrate it counts conversion clocks until the comparator reports a zero crossing. It then latches that count as the magnitude, together with a polarity flag and an over-range flag. A status output is high from the start of integrate until the new result is latched.

The analog integrator and comparator sit outside the block. The comparator reaches it as one digital input, `comp_in`, which is high when the integrator output indicates a positive input. The `run_en` input chooses between continuous conversion and stopping at a fixed point in auto-zero. The `xtal_mode` input chooses whether the conversion clock is the raw system clock or a divided version of it. The divider stands in for a crystal oscillator and divides by 58 by default. The divided clock is delivered as a clock enable, `conv_en`, so that all logic stays in the one clock domain.

Top module: `dual_slope_seq`

## Requirements
- R1: A synchronous active-low reset puts the block in auto-zero with its count at zero. After reset, `phase` is 0, `status` is low, and all three result outputs are zero.
- R2: `phase` encodes 0 = auto-zero, 1 = integrate, 2 = de-integrate and 3 = zero-integrator. Auto-zero lasts AZ_LEN conversion clocks and integrate lasts INT_LEN conversion clocks. The phases follow in the order 0, 1, 2, then 3 or 0.
- R3: With `run_en` high, integrate starts once every AZ_LEN + INT_LEN + DEINT_MAX conversion clocks. With the defaults this is 8192.
- R4: `status` is high during integrate and during de-integrate, and falls on the clock edge that latches the result. It is low during auto-zero and zero-integrator. After a zero crossing the block spends the rest of the DEINT_MAX window in zero-integrator.
- R5: On the last integrate clock the block samples `comp_in` as the polarity. It drives this value on `ref_pos` for the whole de-integrate phase and latches it into `result_pos` (1 = positive).
- R6: The de-integrate count is 0 on the first de-integrate clock. A zero crossing is the first de-integrate clock on which `comp_in` differs from the sampled polarity. The count on that clock becomes `result_mag`, and `result_ovr` is 0.
- R7: If no zero crossing occurs within DEINT_MAX de-integrate clocks, the block sets `result_ovr` to 1 and `result_mag` to all ones, and goes straight to auto-zero.
- R8: When `run_en` is low, the conversion in progress still completes. The block then halts in auto-zero with HOLD_LEAD (7) clocks left before integrate. When `run_en` returns high, integrate starts after exactly HOLD_LEAD more conversion clocks.
- R9: With `xtal_mode` high, `conv_en` is high on one clock in every DIV clocks. The first pulse comes on the DIV-th clock after `xtal_mode` rises. With `xtal_mode` low, `conv_en` is high on every clock.
- R10: Phase, count and polarity change only on clocks where `conv_en` is high.
- R11: The result outputs keep their value between latch events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System / oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_mode | input | 1 | 1 = divide the clock by DIV, 0 = use the clock directly |
| run_en | input | 1 | 1 = convert continuously, 0 = finish the conversion and park |
| comp_in | input | 1 | Comparator output, high for a positive integrator state |
| conv_en | output | 1 | Conversion-clock enable |
| phase | output | 2 | Current phase, encoded as in R2 |
| status | output | 1 | Busy from integrate until the result is latched |
| ref_pos | output | 1 | Reference sign for de-integrate (1 = positive input) |
| result_mag | output | MAG_W (12) | Latched magnitude |
| result_pos | output | 1 | Latched polarity |
| result_ovr | output | 1 | Latched over-range flag |

## Verification
A wrong phase or count register shows up at `phase` and `status` within one conversion clock, because a shortened or extended phase moves the next transition. A miscounted de-integrate count shows up in `result_mag` on the edge where `status` falls. A polarity sampled on the wrong clock shows up on `ref_pos` as soon as de-integrate starts.

A park position off by even one count changes the resume delay. In crystal mode, a divider fault stretches every phase by a multiple of the divider, so the integrate entry time after a resume is wrong by hundreds of clocks.

// File: rtl/dsc_pkg.sv
// Package: shared phase encoding for the dual-slope sequencer.
// Assumes: the encoding below is visible at the top-level ports.
package dsc_pkg;
    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2,
        PH_ZERO  = 2'd3
    } phase_t;
endpackage

// File: rtl/dsc_prescaler.sv
// Module: dsc_prescaler
// Turns the system clock into a conversion-clock enable. In crystal mode the
// enable is high one clock in DIV; otherwise it is high every clock.
// Assumes: DIV >= 1; the count restarts whenever crystal mode is off.
module dsc_prescaler #(
    parameter int DIV = 58
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_mode,
    output logic conv_en
);
    generate
        if (DIV > 1) begin : g_div
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] div_cnt;

            // Divider count: wraps at DIV-1 and is held at zero outside crystal mode.
            always_ff @(posedge clk) begin
                if (!rst_n || !xtal_mode)
                    div_cnt <= '0;
                else if (div_cnt == DW'(DIV - 1))
                    div_cnt <= '0;
                else
                    div_cnt <= div_cnt + DW'(1);
            end

            assign conv_en = !xtal_mode || (div_cnt == DW'(DIV - 1));
        end else begin : g_pass
            logic unused_pins;
            assign unused_pins = &{1'b0, clk, rst_n, xtal_mode};
            assign conv_en = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/dsc_phase_ctrl.sv
// Module: dsc_phase_ctrl
// Phase state machine and shared phase counter. It parks in auto-zero when
// run is low, samples polarity at the end of integrate, and detects the zero
// crossing or the overflow in de-integrate.
// Assumes: AZ_LEN, INT_LEN <= DEINT_MAX; HOLD_LEAD < AZ_LEN; DEINT_MAX a power of two.
module dsc_phase_ctrl
    import dsc_pkg::*;
#(
    parameter int AZ_LEN    = 2048,
    parameter int INT_LEN   = 2048,
    parameter int DEINT_MAX = 4096,
    parameter int HOLD_LEAD = 7,
    localparam int MW       = $clog2(DEINT_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_en,
    input  logic          run_en,
    input  logic          comp_in,
    output phase_t        phase,
    output logic          pol_q,
    output logic          latch_en,
    output logic          ovr_hit,
    output logic [MW-1:0] mag_next
);
    localparam int MAXLEN = (AZ_LEN > INT_LEN) ?
                            ((AZ_LEN > DEINT_MAX) ? AZ_LEN : DEINT_MAX) :
                            ((INT_LEN > DEINT_MAX) ? INT_LEN : DEINT_MAX);
    localparam int CW     = $clog2(MAXLEN);
    localparam int PARK   = AZ_LEN - HOLD_LEAD;

    logic [CW-1:0] cnt;
    logic          crossing;
    logic          deint_last;

    assign crossing   = (comp_in != pol_q);
    assign deint_last = (cnt == CW'(DEINT_MAX - 1));

    // Phase sequencing, counting and polarity capture on each conversion clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_AZ;
            cnt   <= '0;
            pol_q <= 1'b0;
        end else if (conv_en) begin
            case (phase)
                PH_AZ: begin
                    if (cnt == CW'(PARK) && !run_en) begin
                        cnt <= cnt;
                    end else if (cnt == CW'(AZ_LEN - 1)) begin
                        phase <= PH_INT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_INT: begin
                    if (cnt == CW'(INT_LEN - 1)) begin
                        pol_q <= comp_in;
                        phase <= PH_DEINT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_DEINT: begin
                    if (deint_last) begin
                        phase <= PH_AZ;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                        if (crossing)
                            phase <= PH_ZERO;
                    end
                end
                default: begin
                    if (deint_last) begin
                        phase <= PH_AZ;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    // Latch request: a zero crossing, or the end of the de-integrate window.
    always_comb begin
        latch_en = conv_en && (phase == PH_DEINT) && (crossing || deint_last);
        ovr_hit  = !crossing;
        mag_next = ovr_hit ? {MW{1'b1}} : cnt[MW-1:0];
    end
endmodule

// File: rtl/dsc_result_latch.sv
// Module: dsc_result_latch
// Holds magnitude, polarity and over-range between latch requests.
// Assumes: latch_en is a single-cycle pulse from the phase controller.
module dsc_result_latch #(
    parameter int MW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_en,
    input  logic [MW-1:0] mag_in,
    input  logic          pos_in,
    input  logic          ovr_in,
    output logic [MW-1:0] mag_q,
    output logic          pos_q,
    output logic          ovr_q
);
    // Result register: cleared by reset and loaded only on a latch request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            pos_q <= 1'b0;
            ovr_q <= 1'b0;
        end else if (latch_en) begin
            mag_q <= mag_in;
            pos_q <= pos_in;
            ovr_q <= ovr_in;
        end
    end
endmodule

// File: rtl/dual_slope_seq.sv
// Module: dual_slope_seq
// Top level of the dual-slope phase sequencer: prescaler, phase controller
// and result latch. Status is derived from the registered phase.
// Assumes: a single clock domain; comp_in is already synchronous to clk.
module dual_slope_seq
    import dsc_pkg::*;
#(
    parameter int AZ_LEN    = 2048,
    parameter int INT_LEN   = 2048,
    parameter int DEINT_MAX = 4096,
    parameter int HOLD_LEAD = 7,
    parameter int DIV       = 58,
    localparam int MAG_W    = $clog2(DEINT_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_mode,
    input  logic             run_en,
    input  logic             comp_in,
    output logic             conv_en,
    output logic [1:0]       phase,
    output logic             status,
    output logic             ref_pos,
    output logic [MAG_W-1:0] result_mag,
    output logic             result_pos,
    output logic             result_ovr
);
    phase_t           phase_q;
    logic             pol_q;
    logic             latch_en;
    logic             ovr_hit;
    logic [MAG_W-1:0] mag_next;

    dsc_prescaler #(.DIV(DIV)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_mode (xtal_mode),
        .conv_en   (conv_en)
    );

    dsc_phase_ctrl #(
        .AZ_LEN    (AZ_LEN),
        .INT_LEN   (INT_LEN),
        .DEINT_MAX (DEINT_MAX),
        .HOLD_LEAD (HOLD_LEAD)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_en  (conv_en),
        .run_en   (run_en),
        .comp_in  (comp_in),
        .phase    (phase_q),
        .pol_q    (pol_q),
        .latch_en (latch_en),
        .ovr_hit  (ovr_hit),
        .mag_next (mag_next)
    );

    dsc_result_latch #(.MW(MAG_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .mag_in   (mag_next),
        .pos_in   (pol_q),
        .ovr_in   (ovr_hit),
        .mag_q    (result_mag),
        .pos_q    (result_pos),
        .ovr_q    (result_ovr)
    );

    // Port drive: the phase code, busy status and reference sign.
    always_comb begin
        phase   = phase_q;
        status  = (phase_q == PH_INT) || (phase_q == PH_DEINT);
        ref_pos = pol_q;
    end
endmodule

// File: rtl/dsc_checker.sv
// Module: dsc_checker
// Temporal checks on the sequencer ports, bound to dual_slope_seq.
// Assumes: reset is asserted from time zero.
module dsc_checker
    import dsc_pkg::*;
#(
    parameter int MAG_W = 12,
    parameter int DIV   = 58
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xtal_mode,
    input logic             conv_en,
    input logic [1:0]       phase,
    input logic             status,
    input logic             ref_pos,
    input logic [MAG_W-1:0] result_mag,
    input logic             result_pos,
    input logic             result_ovr
);
    a_r11_result_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({result_mag, result_pos, result_ovr}) |-> $fell(status));

    a_r7_ovr_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        result_ovr |-> (&result_mag));

    a_r9_rc_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !xtal_mode |-> conv_en);

    generate
        if (DIV > 1) begin : g_gap
            a_r9_xtal_gap: assert property (@(posedge clk) disable iff (!rst_n)
                (xtal_mode && conv_en) |=> !conv_en);
        end
    endgenerate

    a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> $stable(phase));

    a_r2_after_az: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_AZ) |=> (phase == PH_AZ || phase == PH_INT));

    a_r2_after_int: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INT) |=> (phase == PH_INT || phase == PH_DEINT));

    a_r5_ref_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_INT) |=> $stable(ref_pos));
endmodule

bind dual_slope_seq dsc_checker #(.MAG_W(MAG_W), .DIV(DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xtal_mode  (xtal_mode),
    .conv_en    (conv_en),
    .phase      (phase),
    .status     (status),
    .ref_pos    (ref_pos),
    .result_mag (result_mag),
    .result_pos (result_pos),
    .result_ovr (result_ovr)
);

// File: tb/dual_slope_seq_tb.sv
// Scoreboard bench: the conversion driver queues expected results and a
// monitor pops and compares them when status falls.
module dual_slope_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AZ  = 16;
    localparam int IN  = 16;
    localparam int DM  = 32;
    localparam int HL  = 7;
    localparam int DV  = 58;
    localparam int MW  = $clog2(DM);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_mode = 1'b0;
    logic run_en = 1'b1;
    logic comp_in = 1'b1;
    logic conv_en;
    logic [1:0] phase;
    logic status;
    logic ref_pos;
    logic [MW-1:0] result_mag;
    logic result_pos;
    logic result_ovr;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc = 0;
    int last_start = 0;
    bit per_ok = 1'b0;
    logic [MW+1:0] exp_q[$];

    dual_slope_seq #(
        .AZ_LEN(AZ), .INT_LEN(IN), .DEINT_MAX(DM), .HOLD_LEAD(HL), .DIV(DV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .xtal_mode(xtal_mode), .run_en(run_en),
        .comp_in(comp_in), .conv_en(conv_en), .phase(phase), .status(status),
        .ref_pos(ref_pos), .result_mag(result_mag), .result_pos(result_pos),
        .result_ovr(result_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expectations when status falls; otherwise the result must hold.
    logic          prev_status = 1'b0;
    logic [MW+1:0] prev_res = '0;
    logic [MW+1:0] cur_res;
    logic [MW+1:0] exp_res;
    always @(negedge clk) begin
        if (rst_n) begin
            cur_res = {result_mag, result_pos, result_ovr};
            if (prev_status && !status) begin
                if (exp_q.size() > 0) begin
                    exp_res = exp_q.pop_front();
                    check_eq("R6/R7 latched result", int'(cur_res), int'(exp_res));
                end
            end else if (cur_res !== prev_res) begin
                check_eq("R11 result held", int'(cur_res), int'(prev_res));
            end
            prev_status = status;
            prev_res    = cur_res;
        end
    end

    // Driver: run one scored conversion in RC mode.
    task automatic run_conv(input bit pos, input int k, input bit ovr);
        int n;
        logic [MW+1:0] e;
        while (phase == 2'd1) @(negedge clk);
        while (phase != 2'd1) @(negedge clk);
        if (per_ok) check_eq("R3 conversion period", cyc - last_start, AZ + IN + DM);
        last_start = cyc;
        per_ok = 1'b1;
        comp_in = pos;
        e = {(ovr ? {MW{1'b1}} : MW'(k)), pos, ovr};
        exp_q.push_back(e);
        n = 1;
        @(negedge clk);
        while (phase == 2'd1) begin
            n++;
            @(negedge clk);
        end
        check_eq("R2 integrate length", n, IN);
        check_eq("R5 reference sign", int'(ref_pos), int'(pos));
        check_eq("R4 status in de-integrate", int'(status), 1);
        check_eq("R2 phase code de-integrate", int'(phase), 2);
        if (!ovr) begin
            repeat (k) @(negedge clk);
            comp_in = !pos;
        end
        while (status) @(negedge clk);
        check_eq("R4 phase after latch", int'(phase), (ovr || k == DM - 1) ? 0 : 3);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1 phase", int'(phase), 0);
        check_eq("R1 status", int'(status), 0);
        check_eq("R1 result", int'({result_mag, result_pos, result_ovr}), 0);
        check_eq("R9 rc enable", int'(conv_en), 1);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (phase == 2'd0);
        check_eq("R2 auto-zero length", n, AZ);

        run_conv(1'b1, 5, 1'b0);
        run_conv(1'b0, 0, 1'b0);
        run_conv(1'b1, DM - 1, 1'b0);
        run_conv(1'b0, 0, 1'b1);
        run_conv(1'b1, 12, 1'b0);
        run_conv(1'b0, 20, 1'b0);

        // R8: hold and resume in RC mode
        per_ok = 1'b0;
        run_en = 1'b0;
        repeat (200) @(negedge clk);
        check_eq("R8 parked phase", int'(phase), 0);
        check_eq("R8 parked status", int'(status), 0);
        run_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (phase == 2'd0);
        check_eq("R8 resume lead", n, HL);

        // R9/R10: resume under the crystal divider
        run_en = 1'b0;
        repeat (200) @(negedge clk);
        check_eq("R8 parked again", int'(phase), 0);
        xtal_mode = 1'b1;
        run_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (phase == 2'd0);
        check_eq("R10 divided resume lead", n, HL * DV);
        while (!conv_en) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!conv_en);
        check_eq("R9 enable spacing", n, DV);
        check_eq("R10 integrate held", int'(phase), 1);
        xtal_mode = 1'b0;

        run_conv(1'b1, 7, 1'b0);
        run_conv(1'b0, 3, 1'b0);
        run_conv(1'b1, 0, 1'b1);
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule